// File: doc/BRIEF.md
# Double-Buffered TDM Routing Table

This block is the routing store for a time-slot assigner on a time-division multiplexed serial link. It holds one route entry per slot for each direction, receive and transmit. In dynamic mode, each direction owns two physical banks. One bank is the active route and the other is a shadow. Software rewrites the shadow while the link keeps running. It then raises a per-direction change request. At that direction's next frame sync the two banks trade roles, and the request bit drops by itself.

In fixed mode the banks never trade roles. Software may rewrite any entry, but only while the assigner is held disabled. The slot-lookup ports return the active entry for the presented slot index, one clock later. The fields inside an entry are not interpreted here.

Top module: `tdm_route_table`

## Requirements
- R1: After reset, every output is zero. No request is pending, and the active bank of each direction is physical bank 0.
- R2: The logical entry address is 7 bits wide. Bit 6 selects the direction (0 receive, 1 transmit), bit 5 selects the role (0 active, 1 shadow) and bits 4:0 select the slot. The software read port returns the addressed entry one clock after the address is presented.
- R3: In dynamic mode (`dyn_mode_i`=1), writes addressed to the active role are dropped. Writes addressed to the shadow role land in whichever physical bank is currently the shadow.
- R4: A command write (`cmd_wr_i`=1) sets the receive request from `cmd_data_i[0]` and the transmit request from `cmd_data_i[1]`. A command write is ignored in fixed mode. Setting a request that is already pending has no further effect, so only one swap results.
- R5: A pending request swaps its direction's banks only at an edge where that direction's own sync is high. The request bit clears at that same edge, and the other direction is left untouched.
- R6: A lookup returns the active entry for the slot index one clock later. A lookup presented together with the sync that performs a swap already reads the new active bank.
- R7: Bank roles alternate on every swap. After a swap, the active address reads the former shadow contents, and the shadow address reads the former active contents.
- R8: In fixed mode (`dyn_mode_i`=0), entry writes take effect only while `tsa_en_i` is 0. They are dropped while it is 1.
- R9: A request set in the same cycle as a sync of its direction, with nothing pending before, does not swap at that edge. It stays pending for the following sync.
- R10: A shadow write in the cycle of a swap lands in the bank that is the shadow after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dyn_mode_i | input | 1 | 1: dynamic (shadowed) mode, 0: fixed mode |
| tsa_en_i | input | 1 | Time-slot assigner enabled |
| wr_en_i | input | 1 | Entry write strobe |
| wr_addr_i | input | 7 | Logical entry write address |
| wr_data_i | input | 8 | Entry write data |
| rd_addr_i | input | 7 | Logical entry read address |
| rd_data_o | output | 8 | Entry read data, registered |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_data_i | input | 2 | Request bits: [0] receive, [1] transmit |
| cmd_pend_o | output | 2 | Pending requests: [0] receive, [1] transmit |
| rx_sync_i | input | 1 | Receive frame sync |
| tx_sync_i | input | 1 | Transmit frame sync |
| rx_slot_i | input | 5 | Receive slot index |
| tx_slot_i | input | 5 | Transmit slot index |
| rx_entry_o | output | 8 | Active receive entry, registered |
| tx_entry_o | output | 8 | Active transmit entry, registered |

## Verification
The change request and the frame sync of the same direction can fall in one cycle. So can a shadow write and the swap it races. The bench provokes the first by raising the receive request in the very cycle its sync pulses. It then judges that the lookup still reads the old bank and that the request remains pending until the next sync. It provokes the second by writing the shadow role during the swapping sync. It then judges, through a readback and a lookup, that the data went to the post-swap shadow and not into the newly active bank.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  localparam int unsigned N_DIR = 2;
  localparam int unsigned N_BANK_PER_DIR = 2;
endpackage

// File: rtl/tdm_route_swap_ctl.sv
module tdm_route_swap_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sync_i,
  output logic pend_o,
  output logic sel_o,
  output logic sel_eff_o
);
  logic pend_q, sel_q, swap;

  assign swap      = pend_q & sync_i;
  assign sel_eff_o = sel_q ^ swap;
  assign pend_o    = pend_q;
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (swap) begin
      pend_q <= 1'b0;
      sel_q  <= ~sel_q;
    end else if (req_i) begin
      pend_q <= 1'b1;
    end
  end

  assert_swap_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && sync_i) |=> !pend_q);
  assert_swap_toggles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && sync_i) |=> (sel_q != $past(sel_q)));
  assert_no_swap_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && sync_i) |=> $stable(sel_q));
  assert_set_waits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pend_q) |=> (pend_q && $stable(sel_q)));
endmodule

// File: rtl/tdm_route_mem.sv
module tdm_route_mem #(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned ENTRY_W = 8,
  parameter int unsigned N_RD    = 3,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [ENTRY_W-1:0]            wdata_i,
  input  logic [N_RD-1:0][AW-1:0]       raddr_i,
  output logic [N_RD-1:0][ENTRY_W-1:0]  rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o[p] <= '0;
      else         rdata_o[p] <= mem_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_route_pkg::*;
#(
  parameter int unsigned SLOTS   = 32,
  parameter int unsigned ENTRY_W = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned AW     = SLOT_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dyn_mode_i,
  input  logic               tsa_en_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  input  logic               cmd_wr_i,
  input  logic [N_DIR-1:0]   cmd_data_i,
  output logic [N_DIR-1:0]   cmd_pend_o,
  input  logic               rx_sync_i,
  input  logic               tx_sync_i,
  input  logic [SLOT_W-1:0]  rx_slot_i,
  input  logic [SLOT_W-1:0]  tx_slot_i,
  output logic [ENTRY_W-1:0] rx_entry_o,
  output logic [ENTRY_W-1:0] tx_entry_o
);
  localparam int unsigned DEPTH = N_DIR * N_BANK_PER_DIR * SLOTS;
  localparam int unsigned ROLE_B = AW - 2;
  localparam int unsigned DIR_B  = AW - 1;

  logic [N_DIR-1:0] sync, sel, sel_eff;
  logic             mem_we, wr_ok;
  logic [AW-1:0]    mem_waddr;
  logic [2:0][AW-1:0]      raddr;
  logic [2:0][ENTRY_W-1:0] rdata;

  assign sync = {tx_sync_i, rx_sync_i};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tdm_route_swap_ctl u_swap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (cmd_wr_i & cmd_data_i[d] & dyn_mode_i),
      .sync_i    (sync[d]),
      .pend_o    (cmd_pend_o[d]),
      .sel_o     (sel[d]),
      .sel_eff_o (sel_eff[d])
    );
  end

  // logical role bit xor bank select of its direction gives the physical bank
  function automatic logic [AW-1:0] map_addr(input logic [AW-1:0] a, input logic [N_DIR-1:0] s);
    return {a[DIR_B], a[ROLE_B] ^ s[a[DIR_B]], a[SLOT_W-1:0]};
  endfunction

  assign wr_ok     = dyn_mode_i ? wr_addr_i[ROLE_B] : !tsa_en_i;
  assign mem_we    = wr_en_i & wr_ok;
  assign mem_waddr = map_addr(wr_addr_i, sel_eff);

  assign raddr[0] = map_addr(rd_addr_i, sel_eff);
  assign raddr[1] = {1'b0, sel_eff[DIR_RX], rx_slot_i};
  assign raddr[2] = {1'b1, sel_eff[DIR_TX], tx_slot_i};

  tdm_route_mem #(
    .DEPTH   (DEPTH),
    .ENTRY_W (ENTRY_W),
    .N_RD    (3)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_data_o  = rdata[0];
  assign rx_entry_o = rdata[1];
  assign tx_entry_o = rdata[2];

  assert_fixed_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dyn_mode_i && tsa_en_i) |-> !mem_we);
  assert_active_protect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dyn_mode_i && wr_en_i && !wr_addr_i[ROLE_B]) |-> !mem_we);
  assert_fixed_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dyn_mode_i && cmd_wr_i && (cmd_pend_o == '0)) |=> (cmd_pend_o == '0));
endmodule

// File: tb/tdm_route_table_tb.sv
module tdm_route_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {wr_addr, wr_data, rd_addr, expected}
  localparam logic [29:0] VEC [NVEC] = '{
    {7'h23, 8'hA3, 7'h23, 8'hA3},
    {7'h65, 8'hB5, 7'h65, 8'hB5},
    {7'h03, 8'h11, 7'h03, 8'h00},
    {7'h45, 8'h22, 7'h45, 8'h00},
    {7'h3F, 8'hCF, 7'h3F, 8'hCF},
    {7'h60, 8'hB0, 7'h60, 8'hB0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       dyn_mode = 1'b0, tsa_en = 1'b0, wr_en = 1'b0, cmd_wr = 1'b0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] cmd_data = '0;
  logic       rx_sync = 1'b0, tx_sync = 1'b0;
  logic [4:0] rx_slot = '0, tx_slot = '0;
  logic [7:0] rd_data, rx_entry, tx_entry;
  logic [1:0] cmd_pend;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_route_table u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dyn_mode_i(dyn_mode), .tsa_en_i(tsa_en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data), .cmd_pend_o(cmd_pend),
    .rx_sync_i(rx_sync), .tx_sync_i(tx_sync), .rx_slot_i(rx_slot), .tx_slot_i(tx_slot),
    .rx_entry_o(rx_entry), .tx_entry_o(tx_entry)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [6:0] a, logic [7:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic lk_chk(string tag, logic tx, logic [4:0] s, logic [7:0] exp);
    @(negedge clk); if (tx) tx_slot = s; else rx_slot = s;
    @(negedge clk); chk(tag, tx ? tx_entry : rx_entry, exp);
  endtask

  task automatic cmd(logic [1:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
    @(negedge clk); cmd_wr = 1'b0; cmd_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 rx", rx_entry, 8'h00);
    chk("R1 tx", tx_entry, 8'h00);
    chk("R1 pend", {6'd0, cmd_pend}, 8'h00);
    rst_n = 1'b1;
    dyn_mode = 1'b1; tsa_en = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][29:23], VEC[i][22:15]);
      rd_chk("R2/R3 vec", VEC[i][14:8], VEC[i][7:0]);
    end

    lk_chk("R6 rx active before swap", 1'b0, 5'd3, 8'h00);
    cmd(2'b01);
    chk("R4 rx pend", {6'd0, cmd_pend}, 8'h01);
    lk_chk("R5 no sync no swap", 1'b0, 5'd3, 8'h00);
    @(negedge clk); tx_sync = 1'b1; @(negedge clk); tx_sync = 1'b0;
    chk("R5 tx sync leaves rx pend", {6'd0, cmd_pend}, 8'h01);
    // sync with slot 3 presented: lookup already from new bank
    @(negedge clk); rx_sync = 1'b1; rx_slot = 5'd3;
    @(negedge clk); rx_sync = 1'b0;
    chk("R6 lookup at swap", rx_entry, 8'hA3);
    chk("R5 pend cleared", {6'd0, cmd_pend}, 8'h00);
    rd_chk("R7 active shows old shadow", 7'h03, 8'hA3);
    rd_chk("R7 shadow shows old active", 7'h23, 8'h00);
    lk_chk("R5 tx untouched", 1'b1, 5'd5, 8'h00);

    cmd(2'b10);
    cmd(2'b10);
    chk("R4 tx pend", {6'd0, cmd_pend}, 8'h02);
    @(negedge clk); tx_sync = 1'b1; @(negedge clk); tx_sync = 1'b0;
    chk("R4 single swap clears", {6'd0, cmd_pend}, 8'h00);
    lk_chk("R4 tx one swap", 1'b1, 5'd5, 8'hB5);

    // request and sync together
    @(negedge clk); cmd_wr = 1'b1; cmd_data = 2'b01; rx_sync = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; cmd_data = '0; rx_sync = 1'b0;
    chk("R9 stays pending", {6'd0, cmd_pend}, 8'h01);
    chk("R9 no swap yet", rx_entry, 8'hA3);
    @(negedge clk); rx_sync = 1'b1; @(negedge clk); rx_sync = 1'b0;
    chk("R9 swap at next sync", {6'd0, cmd_pend}, 8'h00);
    lk_chk("R7 alternate back", 1'b0, 5'd3, 8'h00);

    // shadow write during swap
    cmd(2'b01);
    @(negedge clk); rx_sync = 1'b1; wr_en = 1'b1; wr_addr = 7'h23; wr_data = 8'h5A;
    @(negedge clk); rx_sync = 1'b0; wr_en = 1'b0;
    chk("R10 active intact", rx_entry, 8'hA3);
    rd_chk("R10 lands in new shadow", 7'h23, 8'h5A);

    // fixed mode
    dyn_mode = 1'b0; tsa_en = 1'b1;
    wr(7'h10, 8'h77);
    rd_chk("R8 locked while enabled", 7'h10, 8'h00);
    tsa_en = 1'b0;
    wr(7'h10, 8'h77);
    rd_chk("R8 write while disabled", 7'h10, 8'h77);
    cmd(2'b11);
    chk("R4 ignored in fixed", {6'd0, cmd_pend}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule